// File: doc/BRIEF.md
# Conditional trap compare unit

This unit is the decision half of a processor's trap execution stage. It compares two operands in five ways at once: signed less-than, signed greater-than, equal, unsigned less-than and unsigned greater-than. It then masks the five results with a 5-bit condition field taken from the instruction word. A trap is taken when any selected condition holds, or when an upstream stage has already flagged a pending trap cause through a nonzero 5-bit trap-kind code.

In word (32-bit) mode only the low half of each operand counts. The signed comparisons see that half sign-extended, and the unsigned comparisons and equality see it zero-extended. On a taken trap the unit produces the redirect address (the trap vector shifted left by four) and the return address to save (the current instruction address). Four valid flags go with these outputs: the two address flags, plus the two update strobes that the exception-entry logic uses for its machine-state and saved-state registers. When no trap is taken, every flag is low and both addresses are zero. An output register stage can be selected by parameter, which adds one cycle of latency.

Top module: `trap_cond_unit`

## Requirements
- R1: The 5-bit condition mask is `insn_word[25:21]`, with bit 0 as the least significant bit. No other instruction bit affects the outcome.
- R2: When `word_mode` is 0, all five comparisons use the full 64-bit operands.
- R3: When `word_mode` is 1, the signed comparisons use `op_a[31:0]` and `op_b[31:0]` sign-extended to 64 bits.
- R4: When `word_mode` is 1, the unsigned comparisons and equality use `op_a[31:0]` and `op_b[31:0]` zero-extended, so the upper halves are ignored.
- R5: Mask bit 4 selects signed less-than (a<b). Bit 3 selects signed greater-than. Bit 2 selects equal. Bit 1 selects unsigned less-than. Bit 0 selects unsigned greater-than.
- R6: A trap is taken when the bitwise AND of the condition vector and the mask is nonzero.
- R7: A nonzero `trap_kind` forces a taken trap, whatever the operands and mask are.
- R8: On a taken trap, `next_addr` equals `trap_vec` shifted left by 4, truncated to 64 bits.
- R9: On a taken trap, `save_addr` equals `cur_addr`.
- R10: On a taken trap, `next_addr_vld`, `save_addr_vld`, `state_wr_vld` and `save_state_vld` are all 1.
- R11: When no trap is taken, all four valid flags are 0 and `next_addr` and `save_addr` are 0.
- R12: A mask of 0 with `trap_kind` 0 never traps. A mask of all ones always traps.
- R13: With `REG_OUT`=1, the outputs appear one clock after the inputs, and while `rst_n` is low all outputs are 0. With `REG_OUT`=0, the outputs follow the inputs combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| op_a | input | 64 | First compare operand |
| op_b | input | 64 | Second compare operand |
| insn_word | input | 32 | Instruction word; the mask is bits 25:21 |
| word_mode | input | 1 | 1 selects 32-bit comparison |
| trap_kind | input | 5 | Pending trap cause; nonzero forces a trap |
| cur_addr | input | 64 | Address of the current instruction |
| trap_vec | input | 64 | Trap vector, in 16-byte units |
| next_addr | output | 64 | Redirect address on a trap |
| next_addr_vld | output | 1 | `next_addr` is valid |
| save_addr | output | 64 | Return address to save on a trap |
| save_addr_vld | output | 1 | `save_addr` is valid |
| state_wr_vld | output | 1 | Machine-state update strobe for the exception-entry logic |
| save_state_vld | output | 1 | Saved-state update strobe for the exception-entry logic |

## Verification
The bench builds the unit with `XLEN`=64, `HALF`=32 and `REG_OUT`=1. This exercises the registered variant, its one-cycle latency and its reset clearing. The defaults make the sign boundary at bit 31 reachable: in word mode, operands whose upper halves differ but whose low halves match, or whose low halves have bit 31 set, separate the signed results from the unsigned ones. Full-width values such as all ones against one do the same for 64-bit mode. Vectors with the top nibble of `trap_vec` set show the truncation of the shifted vector.

// File: rtl/trapcmp_pkg.sv
package trapcmp_pkg;

  localparam int CMP_W = 5;

  // Bit positions of the condition vector; the mask field decodes against these.
  typedef enum int {
    CMP_UGT = 0,
    CMP_ULT = 1,
    CMP_EQ  = 2,
    CMP_SGT = 3,
    CMP_SLT = 4
  } cmp_bit_e;

  typedef logic [CMP_W-1:0] cmp_vec_t;

endpackage

// File: rtl/trapcmp_compare.sv
module trapcmp_compare
  import trapcmp_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int HALF = 32
) (
  input  logic [XLEN-1:0] op_a,
  input  logic [XLEN-1:0] op_b,
  input  logic            word_mode,
  output cmp_vec_t        cond
);

  localparam int EXT = XLEN - HALF;

  function automatic logic [XLEN-1:0] sext_half(input logic [XLEN-1:0] v);
    return {{EXT{v[HALF-1]}}, v[HALF-1:0]};
  endfunction

  function automatic logic [XLEN-1:0] zext_half(input logic [XLEN-1:0] v);
    return {{EXT{1'b0}}, v[HALF-1:0]};
  endfunction

  function automatic logic s_less(input logic [XLEN-1:0] x, input logic [XLEN-1:0] y);
    return $signed(x) < $signed(y);
  endfunction

  logic [XLEN-1:0] sa, sb, ua, ub;

  always_comb begin
    if (word_mode) begin
      sa = sext_half(op_a);
      sb = sext_half(op_b);
      ua = zext_half(op_a);
      ub = zext_half(op_b);
    end else begin
      sa = op_a;
      sb = op_b;
      ua = op_a;
      ub = op_b;
    end
  end

  always_comb begin
    cond          = '0;
    cond[CMP_SLT] = s_less(sa, sb);
    cond[CMP_SGT] = s_less(sb, sa);
    cond[CMP_EQ]  = (ua == ub);
    cond[CMP_ULT] = (ua < ub);
    cond[CMP_UGT] = (ub < ua);
  end

endmodule

// File: rtl/trapcmp_decide.sv
module trapcmp_decide
  import trapcmp_pkg::*;
#(
  parameter int IW       = 32,
  parameter int MASK_LSB = 21,
  parameter int KIND_W   = 5
) (
  input  logic [IW-1:0]     insn_word,
  input  cmp_vec_t          cond,
  input  logic [KIND_W-1:0] trap_kind,
  output cmp_vec_t          mask,
  output cmp_vec_t          sel,
  output logic              hit
);

  assign mask = insn_word[MASK_LSB +: CMP_W];
  assign sel  = cond & mask;
  assign hit  = (|sel) | (|trap_kind);

endmodule

// File: rtl/trapcmp_outstage.sv
module trapcmp_outstage #(
  parameter int XLEN    = 64,
  parameter int VSHIFT  = 4,
  parameter bit REG_OUT = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hit,
  input  logic [XLEN-1:0] cur_addr,
  input  logic [XLEN-1:0] trap_vec,
  output logic [XLEN-1:0] next_addr,
  output logic [XLEN-1:0] save_addr,
  output logic [3:0]      flags
);

  function automatic logic [XLEN-1:0] redirect(input logic [XLEN-1:0] v);
    return {v[XLEN-VSHIFT-1:0], {VSHIFT{1'b0}}};
  endfunction

  logic [XLEN-1:0] na_c, sa_c;
  logic [3:0]      fl_c;

  always_comb begin
    na_c = hit ? redirect(trap_vec) : '0;
    sa_c = hit ? cur_addr : '0;
    fl_c = {4{hit}};
  end

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          next_addr <= '0;
          save_addr <= '0;
          flags     <= '0;
        end else begin
          next_addr <= na_c;
          save_addr <= sa_c;
          flags     <= fl_c;
        end
      end
    end else begin : g_comb
      assign next_addr = na_c;
      assign save_addr = sa_c;
      assign flags     = fl_c;
    end
  endgenerate

endmodule

// File: rtl/trap_cond_unit.sv
module trap_cond_unit
  import trapcmp_pkg::*;
#(
  parameter int XLEN     = 64,
  parameter int HALF     = 32,
  parameter int IW       = 32,
  parameter int MASK_LSB = 21,
  parameter int KIND_W   = 5,
  parameter int VSHIFT   = 4,
  parameter bit REG_OUT  = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [XLEN-1:0]   op_a,
  input  logic [XLEN-1:0]   op_b,
  input  logic [IW-1:0]     insn_word,
  input  logic              word_mode,
  input  logic [KIND_W-1:0] trap_kind,
  input  logic [XLEN-1:0]   cur_addr,
  input  logic [XLEN-1:0]   trap_vec,
  output logic [XLEN-1:0]   next_addr,
  output logic              next_addr_vld,
  output logic [XLEN-1:0]   save_addr,
  output logic              save_addr_vld,
  output logic              state_wr_vld,
  output logic              save_state_vld
);

  cmp_vec_t   cond_w, mask_w, sel_w;
  logic       hit_w;
  logic [3:0] flags_w;

  trapcmp_compare #(.XLEN(XLEN), .HALF(HALF)) u_cmp (
    .op_a(op_a), .op_b(op_b), .word_mode(word_mode), .cond(cond_w)
  );

  trapcmp_decide #(.IW(IW), .MASK_LSB(MASK_LSB), .KIND_W(KIND_W)) u_dec (
    .insn_word(insn_word), .cond(cond_w), .trap_kind(trap_kind),
    .mask(mask_w), .sel(sel_w), .hit(hit_w)
  );

  trapcmp_outstage #(.XLEN(XLEN), .VSHIFT(VSHIFT), .REG_OUT(REG_OUT)) u_out (
    .clk(clk), .rst_n(rst_n), .hit(hit_w), .cur_addr(cur_addr),
    .trap_vec(trap_vec), .next_addr(next_addr), .save_addr(save_addr),
    .flags(flags_w)
  );

  assign next_addr_vld  = flags_w[0];
  assign save_addr_vld  = flags_w[1];
  assign state_wr_vld   = flags_w[2];
  assign save_state_vld = flags_w[3];

endmodule

// File: rtl/trapcmp_chk.sv
module trapcmp_chk
  import trapcmp_pkg::*;
#(
  parameter int XLEN    = 64,
  parameter int KIND_W  = 5,
  parameter bit REG_OUT = 1'b1
) (
  input logic              clk,
  input logic              rst_n,
  input cmp_vec_t          mask,
  input cmp_vec_t          cond,
  input logic              hit,
  input logic [KIND_W-1:0] trap_kind,
  input logic [XLEN-1:0]   next_addr,
  input logic [XLEN-1:0]   save_addr,
  input logic              next_addr_vld,
  input logic              save_addr_vld,
  input logic              state_wr_vld,
  input logic              save_state_vld
);

  logic [3:0] vlds;
  assign vlds = {save_state_vld, state_wr_vld, save_addr_vld, next_addr_vld};

  // R12
  quiet_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '0 && trap_kind == '0) |-> !hit);

  // R12
  full_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '1) |-> hit);

  // R7
  kind_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_kind != '0) |-> hit);

  // R5
  unsigned_trio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({cond[CMP_EQ], cond[CMP_ULT], cond[CMP_UGT]}) == 1);

  // R5
  signed_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cond[CMP_SLT], cond[CMP_SGT]}) && !(cond[CMP_EQ] && (cond[CMP_SLT] || cond[CMP_SGT])));

  // R10
  flags_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vlds == 4'b0000) || (vlds == 4'b1111));

  // R11
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !next_addr_vld |-> (next_addr == '0 && save_addr == '0));

  // R8
  vec_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    next_addr_vld |-> next_addr[3:0] == 4'b0000);

  generate
    if (REG_OUT) begin : g_lat
      // R13
      lat_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> next_addr_vld);
      // R13
      lat_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |=> !next_addr_vld);
    end else begin : g_now
      // R13
      now_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit == next_addr_vld);
    end
  endgenerate

endmodule

bind trap_cond_unit trapcmp_chk #(.XLEN(XLEN), .KIND_W(KIND_W), .REG_OUT(REG_OUT)) u_chk (
  .clk(clk), .rst_n(rst_n), .mask(mask_w), .cond(cond_w), .hit(hit_w),
  .trap_kind(trap_kind), .next_addr(next_addr), .save_addr(save_addr),
  .next_addr_vld(next_addr_vld), .save_addr_vld(save_addr_vld),
  .state_wr_vld(state_wr_vld), .save_state_vld(save_state_vld)
);

// File: tb/sim_trap_cond_unit.sv
module sim_trap_cond_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] op_a = '0, op_b = '0, cur_addr = '0, trap_vec = '0;
  logic [31:0] insn_word = '0;
  logic        word_mode = 1'b0;
  logic [4:0]  trap_kind = '0;
  logic [63:0] next_addr, save_addr;
  logic        next_addr_vld, save_addr_vld, state_wr_vld, save_state_vld;

  always #5 clk = ~clk;

  trap_cond_unit #(.XLEN(64), .HALF(32), .REG_OUT(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .insn_word(insn_word),
    .word_mode(word_mode), .trap_kind(trap_kind), .cur_addr(cur_addr),
    .trap_vec(trap_vec), .next_addr(next_addr), .next_addr_vld(next_addr_vld),
    .save_addr(save_addr), .save_addr_vld(save_addr_vld),
    .state_wr_vld(state_wr_vld), .save_state_vld(save_state_vld)
  );

  typedef struct {
    logic [63:0] na;
    logic [63:0] sa;
    logic [3:0]  fl;
    string       tag;
  } exp_t;

  exp_t q[$];
  int   n_vec = 0;
  int   n_bad = 0;
  bit   done  = 1'b0;

  function automatic logic [31:0] mk_insn(input logic [4:0] m, input logic [31:0] fill);
    logic [31:0] w;
    w = fill;
    w[25:21] = m;
    return w;
  endfunction

  // Reference: independent restatement of the conditions.
  function automatic logic [4:0] ref_cond(input logic [63:0] a, input logic [63:0] b, input logic wm);
    logic [4:0] c;
    if (wm) begin
      int          sa32, sb32;
      int unsigned ua32, ub32;
      sa32 = int'(a[31:0]);  sb32 = int'(b[31:0]);
      ua32 = a[31:0];        ub32 = b[31:0];
      c = {sa32 < sb32, sa32 > sb32, ua32 == ub32, ua32 < ub32, ua32 > ub32};
    end else begin
      longint sa64, sb64;
      sa64 = longint'(a);    sb64 = longint'(b);
      c = {sa64 < sb64, sa64 > sb64, a == b, a < b, a > b};
    end
    return c;
  endfunction

  task automatic apply(input logic [63:0] a, input logic [63:0] b, input logic [31:0] iw,
                       input logic wm, input logic [4:0] k, input logic [63:0] cia,
                       input logic [63:0] vec, input string tag);
    exp_t e;
    logic take;
    @(negedge clk);
    op_a = a; op_b = b; insn_word = iw; word_mode = wm; trap_kind = k;
    cur_addr = cia; trap_vec = vec;
    take = (|(ref_cond(a, b, wm) & iw[25:21])) || (k != 0);
    e.na  = take ? (vec * 64'd16) : 64'd0;
    e.sa  = take ? cia : 64'd0;
    e.fl  = take ? 4'hF : 4'h0;
    e.tag = tag;
    q.push_back(e);
  endtask

  // Monitor: one item per driven vector, sampled 2 ns after the capturing edge.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (rst_n && q.size() > 0) begin
        exp_t e;
        logic [3:0] fl;
        e  = q.pop_front();
        fl = {save_state_vld, state_wr_vld, save_addr_vld, next_addr_vld};
        n_vec++;
        if (next_addr !== e.na || save_addr !== e.sa || fl !== e.fl) begin
          n_bad++;
          $display("FAIL %s: got na=%h sa=%h fl=%b exp na=%h sa=%h fl=%b",
                   e.tag, next_addr, save_addr, fl, e.na, e.sa, e.fl);
        end
      end
    end
  end

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000) begin
        n_bad++;
        $display("FAIL watchdog: got cycles=%0d exp below 20000", cyc);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
      end
    end
  end

  localparam logic [63:0] CIA = 64'h0000_0000_1000_2004;
  localparam logic [63:0] VEC = 64'h0000_0000_0000_0070;

  initial begin
    repeat (3) @(posedge clk);
    #2;
    n_vec++;
    if ({next_addr, save_addr} !== '0 ||
        {save_state_vld, state_wr_vld, save_addr_vld, next_addr_vld} !== 4'h0) begin
      n_bad++;
      $display("FAIL R13 reset: got na=%h sa=%h exp zeros", next_addr, save_addr);
    end
    @(negedge clk);
    rst_n = 1'b1;

    // R1: bits outside 25:21 set, mask zero -> no trap; mask in field -> trap
    apply(64'd5, 64'd5, mk_insn(5'd0, 32'hFC1F_FFFF), 0, 0, CIA, VEC, "R1 outside bits ignored");
    apply(64'd5, 64'd5, mk_insn(5'b00100, 32'h0), 0, 0, CIA, VEC, "R1 eq bit in field");
    // R5: each mask bit alone against a case with one signed/unsigned split
    apply(64'hFFFF_FFFF_FFFF_FFFF, 64'd1, mk_insn(5'b10000, 0), 0, 0, CIA, VEC, "R5 slt R2 64b");
    apply(64'hFFFF_FFFF_FFFF_FFFF, 64'd1, mk_insn(5'b01000, 0), 0, 0, CIA, VEC, "R5 sgt miss R6");
    apply(64'hFFFF_FFFF_FFFF_FFFF, 64'd1, mk_insn(5'b00001, 0), 0, 0, CIA, VEC, "R5 ugt R2");
    apply(64'hFFFF_FFFF_FFFF_FFFF, 64'd1, mk_insn(5'b00010, 0), 0, 0, CIA, VEC, "R5 ult miss");
    apply(64'd1, 64'hFFFF_FFFF_FFFF_FFFF, mk_insn(5'b01000, 0), 0, 0, CIA, VEC, "R5 sgt hit");
    apply(64'd1, 64'hFFFF_FFFF_FFFF_FFFF, mk_insn(5'b00010, 0), 0, 0, CIA, VEC, "R5 ult hit");
    // R2: upper halves differ, 64-bit mode sees inequality
    apply(64'h1_0000_0007, 64'h2_0000_0007, mk_insn(5'b00100, 0), 0, 0, CIA, VEC, "R2 eq miss 64b");
    // R4: same in word mode -> equal
    apply(64'h1_0000_0007, 64'h2_0000_0007, mk_insn(5'b00100, 0), 1, 0, CIA, VEC, "R4 eq hit 32b");
    apply(64'h1_0000_0007, 64'h2_0000_0007, mk_insn(5'b00011, 0), 1, 0, CIA, VEC, "R4 lt/gt miss 32b");
    // R3: low half 0x80000000 negative in word mode
    apply(64'h0000_0000_8000_0000, 64'd1, mk_insn(5'b10000, 0), 1, 0, CIA, VEC, "R3 slt 32b");
    apply(64'h0000_0000_8000_0000, 64'd1, mk_insn(5'b10000, 0), 0, 0, CIA, VEC, "R3 slt miss 64b");
    apply(64'h0000_0000_8000_0000, 64'd1, mk_insn(5'b00001, 0), 1, 0, CIA, VEC, "R4 ugt 32b");
    // R7: trap kind forces
    apply(64'd3, 64'd3, mk_insn(5'd0, 0), 0, 5'b10000, CIA, VEC, "R7 kind bit4");
    apply(64'd3, 64'd9, mk_insn(5'd0, 0), 1, 5'b00001, CIA, VEC, "R7 kind bit0");
    // R11: idle after trap
    apply(64'd3, 64'd9, mk_insn(5'b01101, 0), 0, 0, CIA, VEC, "R11 idle zeros");
    // R8/R9: vector with top nibble set truncates
    apply(64'd2, 64'd2, mk_insn(5'b11111, 0), 0, 0, 64'hDEAD_BEEF_CAFE_0000,
          64'hF123_4567_89AB_CDEF, "R8 R9 R10 truncation");
    // R12
    apply(64'hAAAA, 64'h5555, mk_insn(5'd0, 32'hFFFF_FFFF & ~32'h03E0_0000), 1, 0, CIA, VEC, "R12 never");
    apply(64'h5555, 64'hAAAA, mk_insn(5'b11111, 0), 1, 0, CIA, VEC, "R12 always");

    for (int i = 0; i < 300; i++) begin
      logic [63:0] ra, rb;
      ra = {$urandom(), $urandom()};
      rb = (i % 4 == 0) ? ra : {$urandom(), $urandom()};
      if (i % 5 == 1) rb[31:0] = ra[31:0];
      apply(ra, rb, $urandom(), i[0], (i % 7 == 0) ? 5'($urandom()) : 5'd0,
            {$urandom(), $urandom()}, {$urandom(), $urandom()}, "R6 R10 random");
    end

    repeat (3) @(posedge clk);
    #3;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule